// File: doc/BRIEF.md
# Parallel-RGB to Seven-Slot Lane Serializer

This block converts one parallel pixel per pixel period into serial slot streams for a low-voltage differential display link. Each pixel carries 8-bit red, green and blue components and three control flags: horizontal sync, vertical sync and data enable. The block packs them into a 7-bit word per data lane and then sends one slot per edge of a clock running seven times the pixel rate. A fifth output carries the matching link clock pattern. The differential pads, the clock multiplier and the video timing generator are outside this block.

Two static inputs shape the output. A 2-bit format select chooses between an 18-bit layout on three lanes and two different 24-bit layouts on four lanes. A mirror flag sends every data lane's slots in the opposite order. Both inputs are taken only while reset is held low. A pixel strobe, one fast-clock cycle wide and repeating every seven fast-clock cycles, marks when the pixel inputs are valid. The block captures the pixel on the strobe and starts a new word at each slot-0 boundary. The inputs may therefore change freely between strobes.

Top module: `lvds_pix_ser`

## Requirements
- R1: While reset is low, and after reset until the first pixel strobe has been acted on, every lane output and the clock lane are 0.
- R2: The pixel sampled on a rising edge where pix_stb is 1 appears as slot 0 after the next rising edge. Slots then advance by one per edge, and a new word begins every 7 edges.
- R3: Over slots 0 to 6 the clock lane drives 1,1,0,0,0,1,1, aligned to the same slot counter as the data lanes.
- R4: With fmt_sel 00 (and also with the unused code 11), the 6-bit components are bits 7:2 of each colour input, so bits 1:0 have no effect. Lane 0 sends slots 0..6 as G0,R5,R4,R3,R2,R1,R0. Lane 1 sends B1,B0,G5,G4,G3,G2,G1. Lane 2 sends the control layout of R7 with B5,B4,B3,B2. Lane 3 stays 0.
- R5: With fmt_sel 01, lanes 0 to 2 are as in R4 using colour bits 7:2. Lane 3 sends slots 0..6 as 0,B1,B0,G1,G0,R1,R0 (8-bit bit numbers).
- R6: With fmt_sel 10, lanes 0 to 2 are as in R4 but use colour bits 5:0. Lane 3 sends slots 0..6 as 0,B7,B6,G7,G6,R7,R6.
- R7: On lane 2, slot 0 is data enable, slot 1 is vertical sync and slot 2 is horizontal sync, in every format. Slot 0 of lane 3 is always 0.
- R8: With mirror set, every data lane sends slot 6 first and slot 0 last. The clock lane is unchanged.
- R9: A word is loaded only at the slot-0 boundary. Changes to the pixel inputs in cycles without a strobe do not alter any word.
- R10: fmt_sel and mirror_in are sampled only while reset is low. Changing them afterwards has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Slot-rate clock, seven times the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset; also loads the format and mirror settings |
| pix_stb | input | 1 | One-cycle pixel-valid strobe, every 7 cycles |
| red_in | input | 8 | Red component |
| grn_in | input | 8 | Green component |
| blu_in | input | 8 | Blue component |
| hsync_in | input | 1 | Horizontal sync |
| vsync_in | input | 1 | Vertical sync |
| de_in | input | 1 | Data enable |
| fmt_sel | input | 2 | Layout: 00 18-bit, 01 24-bit A, 10 24-bit B, 11 as 00 |
| mirror_in | input | 1 | Reverse slot order on data lanes |
| lane_out | output | 4 | Serial data lanes, bit i is lane i |
| clk_lane | output | 1 | Link clock pattern |

## Verification
Every layout is run with mirror off and with mirror on. Pixels include all ones, all zeros and random values. All ones against all zeros exposes stuck or swapped slots. Random values with toggling control flags tell apart any two colour bits that land in the wrong slot or lane. The 18-bit and reserved codes are driven with random low colour bits, so any leak of bits 1:0 shows up. Random garbage is driven on the pixel inputs between strobes, and the mirror input is flipped in the middle of one run. These separate a word that is held correctly from one that follows its inputs or its live settings.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;
    localparam int SLOTS  = 7;                 // slots per pixel period
    localparam int LANES  = 4;                 // data lanes at full width
    localparam int CW     = 8;                 // colour component width
    localparam int MAP_W  = 6;                 // component width per lane group
    localparam int SLOT_W = $clog2(SLOTS);

    typedef enum logic [1:0] {
        FMT_18  = 2'b00,
        FMT_24A = 2'b01,
        FMT_24B = 2'b10,
        FMT_RSV = 2'b11
    } fmt_e;

    typedef struct packed {
        logic [CW-1:0] red;
        logic [CW-1:0] grn;
        logic [CW-1:0] blu;
        logic          hs;
        logic          vs;
        logic          de;
    } pix_t;

    // bit i is the clock lane level in slot i
    localparam logic [SLOTS-1:0] CLK_PAT = 7'b1100011;
endpackage

// File: rtl/lvds_pix_hold.sv
// Pixel holding register.
// Captures the pixel and control inputs on each strobe and raises a sticky
// flag once the first strobe after reset has been seen.
// Assumes pix_stb is synchronous to clk.
module lvds_pix_hold
    import lvds_ser_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  pix_t pix_d,
    output pix_t pix_q,
    output logic seen
);
    // capture on strobe, remember that a strobe has arrived
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q <= '0;
            seen  <= 1'b0;
        end else if (stb) begin
            pix_q <= pix_d;
            seen  <= 1'b1;
        end
    end
endmodule

// File: rtl/lvds_slot_map.sv
// Slot mapper (combinational).
// Arranges one held pixel into a 7-bit word per lane for the selected format.
// Word bit i is the value of slot i. Lane 3 is zero in the 18-bit format.
module lvds_slot_map
    import lvds_ser_pkg::*;
(
    input  fmt_e                           fmt,
    input  pix_t                           pix,
    output logic [LANES-1:0][SLOTS-1:0]    words
);
    // lane 0: green lsb, then red msb down to lsb
    function automatic logic [SLOTS-1:0] map_l0(logic [MAP_W-1:0] r6, logic [MAP_W-1:0] g6);
        logic [SLOTS-1:0] w;
        w[0] = g6[0];
        for (int k = 1; k < SLOTS; k++) w[k] = r6[MAP_W-k];
        return w;
    endfunction

    // lane 1: two blue lsbs, then green msb down to bit 1
    function automatic logic [SLOTS-1:0] map_l1(logic [MAP_W-1:0] g6, logic [MAP_W-1:0] b6);
        logic [SLOTS-1:0] w;
        w[0] = b6[1];
        w[1] = b6[0];
        for (int k = 2; k < SLOTS; k++) w[k] = g6[MAP_W+1-k];
        return w;
    endfunction

    // lane 2: control flags, then blue msb down to bit 2
    function automatic logic [SLOTS-1:0] map_l2(logic hs, logic vs, logic de, logic [MAP_W-1:0] b6);
        logic [SLOTS-1:0] w;
        w[0] = de;
        w[1] = vs;
        w[2] = hs;
        for (int k = 3; k < SLOTS; k++) w[k] = b6[MAP_W+2-k];
        return w;
    endfunction

    // lane 3: constant zero flag, then blue, green, red bit pairs
    function automatic logic [SLOTS-1:0] map_l3(logic [1:0] rp, logic [1:0] gp, logic [1:0] bp);
        return {rp[0], rp[1], gp[0], gp[1], bp[0], bp[1], 1'b0};
    endfunction

    logic [MAP_W-1:0] r6, g6, b6;
    logic             low_grp;

    // choose which six bits feed lanes 0 to 2
    always_comb begin
        low_grp = (fmt == FMT_24B);
        r6 = low_grp ? pix.red[MAP_W-1:0] : pix.red[CW-1 -: MAP_W];
        g6 = low_grp ? pix.grn[MAP_W-1:0] : pix.grn[CW-1 -: MAP_W];
        b6 = low_grp ? pix.blu[MAP_W-1:0] : pix.blu[CW-1 -: MAP_W];
    end

    // build the four lane words
    always_comb begin
        words[0] = map_l0(r6, g6);
        words[1] = map_l1(g6, b6);
        words[2] = map_l2(pix.hs, pix.vs, pix.de, b6);
        case (fmt)
            FMT_24A: words[3] = map_l3(pix.red[1:0], pix.grn[1:0], pix.blu[1:0]);
            FMT_24B: words[3] = map_l3(pix.red[CW-1 -: 2], pix.grn[CW-1 -: 2], pix.blu[CW-1 -: 2]);
            default: words[3] = '0;
        endcase
    end
endmodule

// File: rtl/lvds_lane_ser.sv
// Lane serializer.
// Holds one word per lane and a shared slot counter. It starts on the first
// edge after a strobe has been captured and reloads at every slot-0 boundary.
// Assumes strobes arrive every SLOTS cycles, in step with the counter.
module lvds_lane_ser
    import lvds_ser_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         seen,
    input  logic                         mirror,
    input  logic [LANES-1:0][SLOTS-1:0]  words_in,
    output logic                         running,
    output logic [SLOT_W-1:0]            slot,
    output logic [LANES-1:0][SLOTS-1:0]  word_q,
    output logic [LANES-1:0]             lane_out,
    output logic                         clk_lane
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    logic [SLOT_W-1:0] sel;

    // slot counter, start control and word reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            slot    <= '0;
            word_q  <= '0;
        end else if (!running) begin
            if (seen) begin
                running <= 1'b1;
                slot    <= '0;
                word_q  <= words_in;
            end
        end else if (slot == LAST) begin
            slot   <= '0;
            word_q <= words_in;
        end else begin
            slot <= slot + 1'b1;
        end
    end

    // bit index inside each word, reversed when mirrored
    always_comb sel = mirror ? (LAST - slot) : slot;

    // per-lane output bit
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_out[i] = running & word_q[i][sel];
    end

    // clock lane follows the fixed pattern on the same counter
    assign clk_lane = running & CLK_PAT[slot];
endmodule

// File: rtl/lvds_pix_ser.sv
// Parallel-RGB to seven-slot lane serializer, top level.
// Samples the format and mirror settings while reset is low. Captures pixels
// on pix_stb, maps them to lane words and shifts them out one slot per clock.
// Assumes clk_fast runs at seven times the pixel rate.
module lvds_pix_ser
    import lvds_ser_pkg::*;
(
    input  logic             clk_fast,
    input  logic             rst_n,
    input  logic             pix_stb,
    input  logic [CW-1:0]    red_in,
    input  logic [CW-1:0]    grn_in,
    input  logic [CW-1:0]    blu_in,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic             de_in,
    input  logic [1:0]       fmt_sel,
    input  logic             mirror_in,
    output logic [LANES-1:0] lane_out,
    output logic             clk_lane
);
    fmt_e                         cfg_fmt;
    logic                         cfg_mirror;
    pix_t                         pix_d, pix_q;
    logic                         seen;
    logic [LANES-1:0][SLOTS-1:0]  words;
    logic [LANES-1:0][SLOTS-1:0]  word_q;
    logic                         ser_run;
    logic [SLOT_W-1:0]            ser_slot;

    // static settings, taken only while in reset
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            cfg_fmt    <= fmt_e'(fmt_sel);
            cfg_mirror <= mirror_in;
        end
    end

    // gather the pixel inputs
    always_comb pix_d = '{red: red_in, grn: grn_in, blu: blu_in,
                          hs: hsync_in, vs: vsync_in, de: de_in};

    lvds_pix_hold u_hold (
        .clk   (clk_fast),
        .rst_n (rst_n),
        .stb   (pix_stb),
        .pix_d (pix_d),
        .pix_q (pix_q),
        .seen  (seen)
    );

    lvds_slot_map u_map (
        .fmt   (cfg_fmt),
        .pix   (pix_q),
        .words (words)
    );

    lvds_lane_ser u_ser (
        .clk      (clk_fast),
        .rst_n    (rst_n),
        .seen     (seen),
        .mirror   (cfg_mirror),
        .words_in (words),
        .running  (ser_run),
        .slot     (ser_slot),
        .word_q   (word_q),
        .lane_out (lane_out),
        .clk_lane (clk_lane)
    );
endmodule

// File: rtl/lvds_pix_ser_chk.sv
// Assertion checker for lvds_pix_ser, attached by bind.
module lvds_pix_ser_chk
    import lvds_ser_pkg::*;
(
    input logic                         clk,
    input logic                         rst_n,
    input logic                         running,
    input logic [SLOT_W-1:0]            slot,
    input logic [1:0]                   cfg_fmt,
    input logic                         cfg_mirror,
    input logic [LANES-1:0][SLOTS-1:0]  word_q,
    input logic [LANES-1:0]             lane_out,
    input logic                         clk_lane
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    // R1: quiet outputs until the serializer runs
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (lane_out == '0 && !clk_lane));

    // R2: slots step by one inside a word
    p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && slot != LAST) |=> (slot == $past(slot) + 1'b1));

    // R3: clock lane falls only entering slot 2
    p_clk_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_lane) |-> (slot == 2));

    // R3: clock lane rises only entering slot 5 or at start
    p_clk_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_lane) |-> (slot == 5 || slot == 0));

    // R4: lane 3 idle in the 18-bit formats
    p_lane3_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fmt == 2'b00 || cfg_fmt == 2'b11) |-> !lane_out[3]);

    // R9: words only change at the slot-0 boundary
    p_word_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && slot != LAST) |=> $stable(word_q));

    // R10: settings frozen out of reset
    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ($stable(cfg_fmt) && $stable(cfg_mirror)));
endmodule

bind lvds_pix_ser lvds_pix_ser_chk u_chk (
    .clk        (clk_fast),
    .rst_n      (rst_n),
    .running    (ser_run),
    .slot       (ser_slot),
    .cfg_fmt    (cfg_fmt),
    .cfg_mirror (cfg_mirror),
    .word_q     (word_q),
    .lane_out   (lane_out),
    .clk_lane   (clk_lane)
);

// File: tb/sim_lvds_pix_ser.sv
module sim_lvds_pix_ser;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       pix_stb;
    logic [7:0] red_in, grn_in, blu_in;
    logic       hsync_in, vsync_in, de_in;
    logic [1:0] fmt_sel;
    logic       mirror_in;
    logic [3:0] lane_out;
    logic       clk_lane;

    int n_chk = 0;
    int n_err = 0;

    logic [27:0] exp_q[$];
    logic [1:0]  cur_fmt;
    logic        cur_mir;

    always #2.5 clk = ~clk;

    lvds_pix_ser u0 (
        .clk_fast (clk), .rst_n (rst_n), .pix_stb (pix_stb),
        .red_in (red_in), .grn_in (grn_in), .blu_in (blu_in),
        .hsync_in (hsync_in), .vsync_in (vsync_in), .de_in (de_in),
        .fmt_sel (fmt_sel), .mirror_in (mirror_in),
        .lane_out (lane_out), .clk_lane (clk_lane)
    );

    // expected slot word for one lane (bit i = slot i), written from the tables
    function automatic logic [6:0] model_lane(int ln, logic [1:0] f,
            logic [7:0] r, logic [7:0] g, logic [7:0] b, logic h, logic v, logic d);
        if (f == 2'b10) begin
            case (ln)
                0: return {r[0], r[1], r[2], r[3], r[4], r[5], g[0]};
                1: return {g[1], g[2], g[3], g[4], g[5], b[0], b[1]};
                2: return {b[2], b[3], b[4], b[5], h, v, d};
                default: return {r[6], r[7], g[6], g[7], b[6], b[7], 1'b0};
            endcase
        end
        case (ln)
            0: return {r[2], r[3], r[4], r[5], r[6], r[7], g[2]};
            1: return {g[3], g[4], g[5], g[6], g[7], b[2], b[3]};
            2: return {b[4], b[5], b[6], b[7], h, v, d};
            default: return (f == 2'b01) ? {r[0], r[1], g[0], g[1], b[0], b[1], 1'b0} : 7'd0;
        endcase
    endfunction

    function automatic logic [6:0] rev7(logic [6:0] w);
        logic [6:0] o;
        for (int i = 0; i < 7; i++) o[i] = w[6-i];
        return o;
    endfunction

    task automatic check(string req, string what, logic [6:0] act, logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // driver: one pixel per 7 cycles, garbage on the inputs between strobes
    task automatic send_pixel(logic [7:0] r, logic [7:0] g, logic [7:0] b,
                              logic h, logic v, logic d);
        logic [27:0] e;
        @(negedge clk);
        red_in = r; grn_in = g; blu_in = b;
        hsync_in = h; vsync_in = v; de_in = d;
        pix_stb = 1'b1;
        for (int ln = 0; ln < 4; ln++) begin
            logic [6:0] w;
            w = model_lane(ln, cur_fmt, r, g, b, h, v, d);
            e[ln*7 +: 7] = cur_mir ? rev7(w) : w;   // time order
        end
        exp_q.push_back(e);
        @(negedge clk);
        pix_stb = 1'b0;
        red_in = 8'($urandom); grn_in = 8'($urandom); blu_in = 8'($urandom);
        hsync_in = ~h; vsync_in = ~v; de_in = ~d;
        repeat (5) @(negedge clk);
    endtask

    // monitor: collects seven slots per lane and compares with the queue
    task automatic monitor(int n, int flip_at);
        @(posedge clk iff pix_stb);
        @(posedge clk);
        for (int k = 0; k < n; k++) begin
            logic [6:0] got [4];
            logic [6:0] clk_got;
            logic [27:0] e;
            string tag;
            for (int s = 0; s < 7; s++) begin
                @(negedge clk);
                for (int ln = 0; ln < 4; ln++) got[ln][s] = lane_out[ln];
                clk_got[s] = clk_lane;
                if (s != 6) @(posedge clk);
            end
            e = exp_q.pop_front();
            check("R3", "clock lane pattern", clk_got, 7'b1100011);
            if (k == 0)            tag = "R2";
            else if (k >= flip_at) tag = "R10";
            else if (k == 1)       tag = "R9";
            else if (cur_mir)      tag = "R8";
            else if (cur_fmt == 2'b01) tag = "R5";
            else if (cur_fmt == 2'b10) tag = "R6";
            else                   tag = "R4";
            for (int ln = 0; ln < 4; ln++)
                check((ln == 2 && k > 1 && k < flip_at) ? "R7" : tag,
                      $sformatf("fmt %0d mir %0d word %0d lane %0d", cur_fmt, cur_mir, k, ln),
                      got[ln], e[ln*7 +: 7]);
            if (k != n - 1) @(posedge clk);
        end
    endtask

    task automatic run_case(logic [1:0] f, logic m, int n, int flip_at);
        rst_n = 1'b0; pix_stb = 1'b0;
        fmt_sel = f; mirror_in = m; cur_fmt = f; cur_mir = m;
        red_in = '0; grn_in = '0; blu_in = '0;
        hsync_in = 0; vsync_in = 0; de_in = 0;
        repeat (3) @(negedge clk);
        check("R1", "outputs in reset", {2'b0, clk_lane, lane_out}, 7'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", "outputs before strobe", {2'b0, clk_lane, lane_out}, 7'd0);
        fork
            begin
                for (int k = 0; k < n; k++) begin
                    if (k == flip_at) begin
                        mirror_in = ~m;
                        fmt_sel = ~f;
                    end
                    if (k == 0)      send_pixel(8'hFF, 8'hFF, 8'hFF, 1, 1, 1);
                    else if (k == 1) send_pixel(8'h00, 8'h00, 8'h00, 0, 0, 0);
                    else send_pixel(8'($urandom), 8'($urandom), 8'($urandom),
                                    k[0], k[1], k[2]);
                end
            end
            monitor(n, flip_at);
        join
        repeat (3) @(negedge clk);
    endtask

    // watchdog: a hung run counts as a failed check
    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        run_case(2'b00, 1'b0, 8, 99);  // R4 18-bit
        run_case(2'b01, 1'b0, 8, 99);  // R5 layout A
        run_case(2'b10, 1'b0, 8, 99);  // R6 layout B
        run_case(2'b11, 1'b0, 6, 99);  // R4 reserved code
        run_case(2'b00, 1'b1, 6, 99);  // R8 mirror
        run_case(2'b01, 1'b1, 6, 99);  // R8 mirror
        run_case(2'b10, 1'b1, 6, 99);  // R8 mirror
        run_case(2'b01, 1'b0, 8, 4);   // R10 settings changed mid-run
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule